// File: doc/BRIEF.md
# Controller-to-Host Mailbox Interrupt Registers

This block holds three byte-wide registers that an embedded controller and a host share: a pending-source register, an enable mask and a one-byte outbound mailbox. Each side reaches the registers through its own simple synchronous port (address, write strobe, write data, read strobe, read data). The two ports see the same bits under different rules. The controller owns the software interrupt bits outright, and the host can only acknowledge them by writing ones. A delivery flag marks a mailbox byte that the host has not yet collected. A controller write to the mailbox raises this flag and a host read of the mailbox lowers it. The controller cannot see the flag.

A single registered request line goes to the host whenever any pending bit has its enable set. A typical exchange runs as follows. The controller drops a byte into the mailbox, or sets a software bit, and the host takes the interrupt. The host then reads the pending register to find the cause, and acknowledges by reading the mailbox or by writing ones to the software bits.

Top module: `mbx_irq_regs`

## Requirements
- R1: After the asynchronous active-low reset, the pending, mask and mailbox registers read 0x00 on both ports, both read-data outputs are 0x00 and the host request is low.
- R2: A controller write at controller offset 0x00 stores the byte in the mailbox, and a host read at host index 0x01 returns it. Host writes to that index are ignored.
- R3: A controller write to the mailbox sets the delivery flag, which the host sees as bit 0 of a read at host index 0x96.
- R4: A host read of the mailbox clears the delivery flag. If a controller mailbox write happens in the same cycle, the flag is set.
- R5: At controller offset 0x08, reads return 0 in bit 0, and the controller write value in bit 0 has no effect on the delivery flag.
- R6: Bits 7:1 of the pending register are read and written directly by the controller at offset 0x08. A host write at index 0x96 clears each of those bits written with 1, leaves bits written with 0 unchanged and does not touch the delivery flag.
- R7: If a controller write at offset 0x08 and a host clear at index 0x96 happen in the same cycle, the software bits take the controller value.
- R8: The mask is read/write at controller offset 0x0C and host index 0x97. If both ports write it in the same cycle, the controller value is kept.
- R9: The host request equals the OR over all bits of (pending AND mask), registered, so it follows a change one clock later.
- R10: Read data is registered: it appears one clock after the read strobe and holds while no read is strobed. Unmapped addresses read 0x00 on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ec_addr_i | input | 8 | Controller register offset |
| ec_we_i | input | 1 | Controller write strobe |
| ec_wdata_i | input | 8 | Controller write data |
| ec_re_i | input | 1 | Controller read strobe |
| ec_rdata_o | output | 8 | Controller read data, one clock after strobe |
| host_addr_i | input | 8 | Host mailbox index |
| host_we_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Host write data |
| host_re_i | input | 1 | Host read strobe |
| host_rdata_o | output | 8 | Host read data, one clock after strobe |
| host_irq_o | output | 1 | Registered host interrupt request |

## Verification
The assertions assume that each strobe is a clean, known level on every clock edge after reset. They also assume that an address and its write data are valid whenever the matching strobe is high. Strobes on the two ports may coincide freely, and the collision properties depend on that. The bench drives every input on the falling edge and holds it for one full cycle. It returns all strobes to zero between operations and deliberately places controller and host accesses in the same cycle for the mailbox flag, the software bits and the mask.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned SWI_W = REG_W - 1;

  typedef logic [REG_W-1:0] reg_t;
  typedef logic [SWI_W-1:0] swi_t;

  typedef struct packed {
    logic ec_src_wr;
    logic ec_mask_wr;
    logic ec_data_wr;
    logic host_src_w1c;
    logic host_mask_wr;
    logic host_data_rd;
  } strobe_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_SRC  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_DATA = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec
  import mbx_irq_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] EC_DATA_OFS   = 'h00,
  parameter logic [AW-1:0] EC_SRC_OFS    = 'h08,
  parameter logic [AW-1:0] EC_MASK_OFS   = 'h0C,
  parameter logic [AW-1:0] HOST_DATA_IDX = 'h01,
  parameter logic [AW-1:0] HOST_SRC_IDX  = 'h96,
  parameter logic [AW-1:0] HOST_MASK_IDX = 'h97
) (
  input  logic [AW-1:0] ec_addr_i,
  input  logic          ec_we_i,
  input  logic          ec_re_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic          host_we_i,
  input  logic          host_re_i,
  output strobe_t       stb_o,
  output rd_sel_e       ec_sel_o,
  output rd_sel_e       host_sel_o
);
  rd_sel_e ec_hit, host_hit;

  always_comb begin
    if (ec_addr_i == EC_SRC_OFS)       ec_hit = SEL_SRC;
    else if (ec_addr_i == EC_MASK_OFS) ec_hit = SEL_MASK;
    else if (ec_addr_i == EC_DATA_OFS) ec_hit = SEL_DATA;
    else                               ec_hit = SEL_NONE;
  end

  always_comb begin
    if (host_addr_i == HOST_SRC_IDX)       host_hit = SEL_SRC;
    else if (host_addr_i == HOST_MASK_IDX) host_hit = SEL_MASK;
    else if (host_addr_i == HOST_DATA_IDX) host_hit = SEL_DATA;
    else                                   host_hit = SEL_NONE;
  end

  always_comb begin
    stb_o              = '0;
    stb_o.ec_src_wr    = ec_we_i   && (ec_hit == SEL_SRC);
    stb_o.ec_mask_wr   = ec_we_i   && (ec_hit == SEL_MASK);
    stb_o.ec_data_wr   = ec_we_i   && (ec_hit == SEL_DATA);
    stb_o.host_src_w1c = host_we_i && (host_hit == SEL_SRC);
    stb_o.host_mask_wr = host_we_i && (host_hit == SEL_MASK);
    // host data index is read-only; writes decode to nothing
    stb_o.host_data_rd = host_re_i && (host_hit == SEL_DATA);
  end

  assign ec_sel_o   = ec_re_i   ? ec_hit   : SEL_NONE;
  assign host_sel_o = host_re_i ? host_hit : SEL_NONE;
endmodule

// File: rtl/mbx_src_reg.sv
module mbx_src_reg
  import mbx_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ec_wr_i,
  input  reg_t ec_wdata_i,
  input  logic host_w1c_i,
  input  reg_t host_wdata_i,
  input  logic mbx_set_i,
  input  logic mbx_clr_i,
  output reg_t src_o
);
  swi_t swi_q;
  logic flag_q;

  // controller write has priority over host acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         swi_q <= '0;
    else if (ec_wr_i)    swi_q <= ec_wdata_i[REG_W-1:1];
    else if (host_w1c_i) swi_q <= swi_q & ~host_wdata_i[REG_W-1:1];
  end

  // set beats clear on collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (mbx_set_i) flag_q <= 1'b1;
    else if (mbx_clr_i) flag_q <= 1'b0;
  end

  assign src_o = {swi_q, flag_q};

  assert_flag_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbx_set_i |=> src_o[0]);
  assert_flag_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbx_clr_i && !mbx_set_i) |=> !src_o[0]);
  assert_flag_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mbx_set_i && !mbx_clr_i) |=> $stable(src_o[0]));
  assert_swi_ec_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ec_wr_i |=> (src_o[REG_W-1:1] == $past(ec_wdata_i[REG_W-1:1])));
  assert_swi_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_w1c_i && !ec_wr_i) |=> ((src_o[REG_W-1:1] & $past(host_wdata_i[REG_W-1:1])) == '0));
  assert_swi_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_w1c_i && !ec_wr_i) |=> $stable(src_o[REG_W-1:1]));
endmodule

// File: rtl/mbx_rw_reg.sv
module mbx_rw_reg
  import mbx_irq_pkg::*;
#(
  parameter bit HAS_HOST_WR = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ec_wr_i,
  input  reg_t ec_wdata_i,
  input  logic host_wr_i,
  input  reg_t host_wdata_i,
  output reg_t q_o
);
  reg_t q;
  logic host_wr;

  generate
    if (HAS_HOST_WR) begin : g_host
      assign host_wr = host_wr_i;
    end else begin : g_ec_only
      assign host_wr = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (ec_wr_i) q <= ec_wdata_i;
    else if (host_wr) q <= host_wdata_i;
  end

  assign q_o = q;

  assert_ec_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ec_wr_i |=> (q_o == $past(ec_wdata_i)));
  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ec_wr_i && !host_wr) |=> $stable(q_o));
endmodule

// File: rtl/mbx_irq_out.sv
module mbx_irq_out
  import mbx_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  reg_t src_i,
  input  reg_t mask_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(src_i & mask_i);
  end

  assign irq_o = irq_q;

  assert_irq_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_i & mask_i) == '0) |=> !irq_o);
  assert_irq_raise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(src_i & mask_i) != 0) |=> irq_o);
endmodule

// File: rtl/mbx_irq_regs.sv
module mbx_irq_regs
  import mbx_irq_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] EC_DATA_OFS   = 'h00,
  parameter logic [AW-1:0] EC_SRC_OFS    = 'h08,
  parameter logic [AW-1:0] EC_MASK_OFS   = 'h0C,
  parameter logic [AW-1:0] HOST_DATA_IDX = 'h01,
  parameter logic [AW-1:0] HOST_SRC_IDX  = 'h96,
  parameter logic [AW-1:0] HOST_MASK_IDX = 'h97
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ec_addr_i,
  input  logic          ec_we_i,
  input  logic [7:0]    ec_wdata_i,
  input  logic          ec_re_i,
  output logic [7:0]    ec_rdata_o,
  input  logic [AW-1:0] host_addr_i,
  input  logic          host_we_i,
  input  logic [7:0]    host_wdata_i,
  input  logic          host_re_i,
  output logic [7:0]    host_rdata_o,
  output logic          host_irq_o
);
  strobe_t stb;
  rd_sel_e ec_sel, host_sel;
  reg_t    src, mask, data;
  reg_t    ec_rd_d, host_rd_d, ec_rd_q, host_rd_q;

  mbx_addr_dec #(
    .AW(AW), .EC_DATA_OFS(EC_DATA_OFS), .EC_SRC_OFS(EC_SRC_OFS),
    .EC_MASK_OFS(EC_MASK_OFS), .HOST_DATA_IDX(HOST_DATA_IDX),
    .HOST_SRC_IDX(HOST_SRC_IDX), .HOST_MASK_IDX(HOST_MASK_IDX)
  ) u_dec (
    .ec_addr_i, .ec_we_i, .ec_re_i,
    .host_addr_i, .host_we_i, .host_re_i,
    .stb_o(stb), .ec_sel_o(ec_sel), .host_sel_o(host_sel)
  );

  mbx_src_reg u_src (
    .clk_i, .rst_ni,
    .ec_wr_i(stb.ec_src_wr), .ec_wdata_i(ec_wdata_i),
    .host_w1c_i(stb.host_src_w1c), .host_wdata_i(host_wdata_i),
    .mbx_set_i(stb.ec_data_wr), .mbx_clr_i(stb.host_data_rd),
    .src_o(src)
  );

  mbx_rw_reg #(.HAS_HOST_WR(1'b1)) u_mask (
    .clk_i, .rst_ni,
    .ec_wr_i(stb.ec_mask_wr), .ec_wdata_i(ec_wdata_i),
    .host_wr_i(stb.host_mask_wr), .host_wdata_i(host_wdata_i),
    .q_o(mask)
  );

  mbx_rw_reg #(.HAS_HOST_WR(1'b0)) u_data (
    .clk_i, .rst_ni,
    .ec_wr_i(stb.ec_data_wr), .ec_wdata_i(ec_wdata_i),
    .host_wr_i(1'b0), .host_wdata_i('0),
    .q_o(data)
  );

  mbx_irq_out u_irq (
    .clk_i, .rst_ni, .src_i(src), .mask_i(mask), .irq_o(host_irq_o)
  );

  // controller never sees the delivery flag
  always_comb begin
    unique case (ec_sel)
      SEL_SRC:  ec_rd_d = {src[REG_W-1:1], 1'b0};
      SEL_MASK: ec_rd_d = mask;
      SEL_DATA: ec_rd_d = data;
      default:  ec_rd_d = '0;
    endcase
  end

  always_comb begin
    unique case (host_sel)
      SEL_SRC:  host_rd_d = src;
      SEL_MASK: host_rd_d = mask;
      SEL_DATA: host_rd_d = data;
      default:  host_rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ec_rd_q   <= '0;
      host_rd_q <= '0;
    end else begin
      if (ec_re_i)   ec_rd_q   <= ec_rd_d;
      if (host_re_i) host_rd_q <= host_rd_d;
    end
  end

  assign ec_rdata_o   = ec_rd_q;
  assign host_rdata_o = host_rd_q;

  assert_ec_flag_hidden_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ec_re_i && ec_addr_i == EC_SRC_OFS) |=> !ec_rdata_o[0]);
  assert_ec_rd_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ec_re_i |=> $stable(ec_rdata_o));
  assert_host_rd_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_re_i |=> $stable(host_rdata_o));
  assert_host_unmapped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_re_i && host_addr_i != HOST_SRC_IDX && host_addr_i != HOST_MASK_IDX &&
     host_addr_i != HOST_DATA_IDX) |=> (host_rdata_o == '0));
  assert_mbx_rd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_re_i && host_addr_i == HOST_DATA_IDX && !ec_we_i) |=> (host_rdata_o == $past(data)));
endmodule

// File: tb/mbx_irq_regs_tb_top.sv
module mbx_irq_regs_tb_top;
  localparam logic [7:0] E_DATA = 8'h00, E_SRC = 8'h08, E_MASK = 8'h0C;
  localparam logic [7:0] H_DATA = 8'h01, H_SRC = 8'h96, H_MASK = 8'h97;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] ec_addr = '0, ec_wdata = '0, host_addr = '0, host_wdata = '0;
  logic ec_we = 0, ec_re = 0, host_we = 0, host_re = 0;
  logic [7:0] ec_rdata, host_rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mbx_irq_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ec_addr_i(ec_addr), .ec_we_i(ec_we), .ec_wdata_i(ec_wdata), .ec_re_i(ec_re),
    .ec_rdata_o(ec_rdata),
    .host_addr_i(host_addr), .host_we_i(host_we), .host_wdata_i(host_wdata),
    .host_re_i(host_re), .host_rdata_o(host_rdata), .host_irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one cycle: inputs set at falling edge, results sampled at next falling edge
  task automatic step(input logic ew, input logic er, input logic [7:0] ea, input logic [7:0] ed,
                      input logic hw, input logic hr, input logic [7:0] ha, input logic [7:0] hd);
    @(negedge clk);
    ec_we = ew; ec_re = er; ec_addr = ea; ec_wdata = ed;
    host_we = hw; host_re = hr; host_addr = ha; host_wdata = hd;
    @(negedge clk);
    ec_we = 0; ec_re = 0; host_we = 0; host_re = 0;
  endtask

  task automatic ec_wr(input logic [7:0] a, input logic [7:0] d);
    step(1, 0, a, d, 0, 0, 8'h00, 8'h00);
  endtask
  task automatic ec_rd(input logic [7:0] a);
    step(0, 1, a, 8'h00, 0, 0, 8'h00, 8'h00);
  endtask
  task automatic h_wr(input logic [7:0] a, input logic [7:0] d);
    step(0, 0, 8'h00, 8'h00, 1, 0, a, d);
  endtask
  task automatic h_rd(input logic [7:0] a);
    step(0, 0, 8'h00, 8'h00, 0, 1, a, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev_m;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 ec_rdata", ec_rdata, 8'h00);
    chk("R1 host_rdata", host_rdata, 8'h00);
    rst_n = 1'b1;
    h_rd(H_SRC);  chk("R1 host src", host_rdata, 8'h00);
    h_rd(H_MASK); chk("R1 host mask", host_rdata, 8'h00);
    h_rd(H_DATA); chk("R1 host data", host_rdata, 8'h00);
    ec_rd(E_MASK); chk("R1 ec mask", ec_rdata, 8'h00);

    // R2 R3 R4 R5: mailbox sweep over every byte
    for (int v = 0; v < 256; v++) begin
      ec_wr(E_DATA, v[7:0]);
      h_rd(H_SRC);  chk("R3 flag set", host_rdata, 8'h01);
      ec_rd(E_SRC); chk("R5 flag hidden", ec_rdata, 8'h00);
      h_wr(H_DATA, ~v[7:0]);
      h_rd(H_DATA); chk("R2 mailbox data", host_rdata, v[7:0]);
      h_rd(H_SRC);  chk("R4 flag cleared", host_rdata, 8'h00);
    end
    ec_rd(E_DATA); chk("R2 ec readback", ec_rdata, 8'hFF);

    // R4 collision: controller write and host read together
    step(1, 0, E_DATA, 8'h5A, 0, 1, H_DATA, 8'h00);
    chk("R4 collision old data", host_rdata, 8'hFF);
    h_rd(H_SRC); chk("R4 collision set wins", host_rdata, 8'h01);

    // R5: controller writes to bit 0 are ignored
    ec_wr(E_SRC, 8'h00);
    h_rd(H_SRC); chk("R5 ec clear ignored", host_rdata, 8'h01);
    h_rd(H_DATA);
    ec_wr(E_SRC, 8'h01);
    h_rd(H_SRC); chk("R5 ec set ignored", host_rdata, 8'h00);

    // R6 R7: software bits
    for (int a = 0; a < 128; a++) begin
      logic [6:0] av, cv;
      av = a[6:0];
      cv = 7'((a * 37 + 5) & 127);
      ec_wr(E_SRC, {av, 1'b1});
      ec_rd(E_SRC); chk("R6 ec readback", ec_rdata, {av, 1'b0});
      h_wr(H_SRC, {cv, 1'b1});
      h_rd(H_SRC);  chk("R6 host w1c", host_rdata, {av & ~cv, 1'b0});
      if ((a % 8) == 3) begin
        step(1, 0, E_SRC, {~av, 1'b0}, 1, 0, H_SRC, 8'hFF);
        h_rd(H_SRC); chk("R7 ec beats w1c", host_rdata, {~av, 1'b0});
      end
    end
    ec_wr(E_DATA, 8'h33);
    ec_wr(E_SRC, 8'hAA);
    h_wr(H_SRC, 8'h01);
    h_rd(H_SRC); chk("R6 bit0 w1c ignored", host_rdata, 8'hAB);
    h_rd(H_DATA);
    ec_wr(E_SRC, 8'h00);

    // R8: mask from both ports
    for (int m = 0; m < 256; m++) begin
      if (m % 2 == 0) ec_wr(E_MASK, m[7:0]);
      else            h_wr(H_MASK, m[7:0]);
      ec_rd(E_MASK); chk("R8 ec mask", ec_rdata, m[7:0]);
      h_rd(H_MASK);  chk("R8 host mask", host_rdata, m[7:0]);
    end
    step(1, 0, E_MASK, 8'h3C, 1, 0, H_MASK, 8'hC3);
    h_rd(H_MASK); chk("R8 ec wins", host_rdata, 8'h3C);

    // R9: request = OR(src & mask), one cycle late
    ec_wr(E_MASK, 8'h00);
    prev_m = 8'h00;
    for (int s = 0; s < 256; s++) begin
      logic [7:0] sv, mv;
      sv = s[7:0];
      mv = 8'((s * 29 + 3) & 255);
      ec_wr(E_SRC, sv);
      if (sv[0]) ec_wr(E_DATA, 8'h11);
      else       h_rd(H_DATA);
      ec_wr(E_MASK, mv);
      chk("R9 irq before", {7'd0, irq}, {7'd0, |(sv & prev_m)});
      step(0, 0, 8'h00, 8'h00, 0, 0, 8'h00, 8'h00);
      chk("R9 irq after", {7'd0, irq}, {7'd0, |(sv & mv)});
      prev_m = mv;
    end

    // R10: read timing and unmapped addresses
    ec_wr(E_MASK, 8'h69);
    ec_rd(E_MASK);
    step(0, 0, E_MASK, 8'h00, 0, 0, H_MASK, 8'h00);
    chk("R10 ec hold", ec_rdata, 8'h69);
    ec_rd(8'h04);  chk("R10 ec unmapped", ec_rdata, 8'h00);
    h_rd(H_MASK);
    step(0, 0, 8'h00, 8'h00, 0, 0, 8'h20, 8'h00);
    chk("R10 host hold", host_rdata, 8'h69);
    h_rd(8'h98);   chk("R10 host unmapped", host_rdata, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule